// File: doc/BRIEF.md
# Interrupt Entry and Acknowledge Front End

This block sits between one external interrupt line and a processor pipeline. It turns the line into a take-interrupt request, gated by the interrupt-enable bit of the machine status word. A compile-time parameter chooses how the line is read. In level mode the line itself is the request. In edge mode a rising edge is caught in a pending latch, and that latch holds the request until it is serviced. Capture does not depend on the enable bit, so an edge that arrives while interrupts are masked is taken as soon as they are enabled again.

The pipeline accepts a request by raising `takeReady` in a cycle where `takeReq` is high. At that clock edge the block clears the enable bit and the pending latch. The handler address is offered on `takeVec`. With the low-latency parameter set, it is the vector that an external controller supplies alongside the request. Otherwise it is a fixed default address. The block also reports handling events to the controller through a 2-bit code: handler entry, return from interrupt, and re-enable. Each code lasts one cycle.

Top module: `irq_entry_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `enState` is 0, `ackCode` is 00 and `takeReq` is 0. `takeReq` is never high while `enState` is 0.
- R2: With EDGE_MODE=0 nothing is latched. `takeReq` equals `enState & irqIn` in the same cycle, and it drops if the line drops before the take.
- R3: With EDGE_MODE=1, a one-cycle high pulse on `irqIn` sets the pending latch at the following edge. `takeReq` is then high from the next cycle while enabled, until the request is taken.
- R4: With EDGE_MODE=1, a line held high yields one request only. A new request needs the line to be low for at least one sampled cycle first.
- R5: With EDGE_MODE=1, edges are latched while `enState` is 0. The latched request raises `takeReq` in the cycle after enable becomes 1.
- R6: `takeVec` equals `vecIn` when LOW_LATENCY=1 and equals DEFAULT_VEC when LOW_LATENCY=0.
- R7: A take (`takeReq & takeReady` at an edge) clears `enState` and the pending latch at that edge. `ackCode` is 01 in the next cycle.
- R8: `retExec` without a take sets `enState` to 1, and `ackCode` is 10 in the next cycle. This code wins over the re-enable code.
- R9: `enSet` while `enState` is 0 (no return in the same cycle) sets the enable bit and gives `ackCode` 11 in the next cycle. `enSet` while already enabled gives 00. `enClr` clears the enable bit and gives no code.
- R10: `ackCode` is nonzero only in the cycle after an event. With no event it returns to 00, so a single event yields a single-cycle code.
- R11: With EDGE_MODE=1, a rising edge in the same cycle as a take is latched as a new pending request.
- R12: A take has priority over `retExec`, `enSet` and `enClr` in the same cycle: code 01, enable cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irqIn | input | 1 | External interrupt line |
| vecIn | input | ADDR_W | Handler address supplied with the request |
| takeReady | input | 1 | Pipeline accepts the request this cycle |
| retExec | input | 1 | Return-from-interrupt executes this cycle |
| enSet | input | 1 | Software writes enable bit to 1 |
| enClr | input | 1 | Software writes enable bit to 0 |
| takeReq | output | 1 | Take-interrupt request to the pipeline |
| takeVec | output | ADDR_W | Handler address to redirect to |
| enState | output | 1 | Current interrupt-enable bit |
| ackCode | output | 2 | Event code: 01 entry, 10 return, 11 re-enable, 00 idle |

## Verification
The bench builds two copies that share the same stimulus. One uses EDGE_MODE=1 with LOW_LATENCY=1 and the other uses EDGE_MODE=0 with LOW_LATENCY=0, so both ways of reading the line and both vector sources are covered. Running them side by side sets latched edges against a held level. This reaches masked-edge capture, held-high lines, an edge that lands in a take cycle, and level requests that vanish before they are taken. A directed run of same-cycle return, re-enable and take events is followed by a long random run.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  // Event code reported to the external controller.
  typedef enum logic [1:0] {
    ACK_IDLE     = 2'b00,
    ACK_ENTER    = 2'b01,
    ACK_RETURN   = 2'b10,
    ACK_REENABLE = 2'b11
  } ackCode_e;

  // Strobes the control side hands to the datapath side.
  typedef struct packed {
    logic takeNow;      // interrupt accepted at this edge
    logic dropPending;  // clear the captured request
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_entry_datapath.sv
module irq_entry_datapath
  import irq_entry_pkg::*;
#(
  parameter bit EDGE_MODE = 1'b1,
  parameter bit LOW_LATENCY = 1'b1,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] DEFAULT_VEC = 32'h0000_0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irqIn,
  input  logic [ADDR_W-1:0] vecIn,
  input  ctrlStrobe_t       strobe,
  output logic              reqLive,
  output logic [ADDR_W-1:0] vecOut
);

  generate
    if (EDGE_MODE) begin : g_edge
      logic prevIn;
      logic pending;
      logic riseSeen;

      // A rise needs the previous sampled level to be low.
      assign riseSeen = irqIn & ~prevIn;

      always_ff @(posedge clk) begin
        if (rst) begin
          prevIn  <= 1'b0;
          pending <= 1'b0;
        end else begin
          prevIn  <= irqIn;
          // A fresh edge survives a same-cycle clear.
          pending <= riseSeen | (pending & ~strobe.dropPending);
        end
      end

      assign reqLive = pending;
    end else begin : g_level
      logic unusedSig;
      assign unusedSig = clk ^ rst ^ strobe.takeNow ^ strobe.dropPending;
      assign reqLive = irqIn;
    end
  endgenerate

  generate
    if (LOW_LATENCY) begin : g_direct
      assign vecOut = vecIn;
    end else begin : g_fixed
      logic [ADDR_W-1:0] unusedVec;
      assign unusedVec = vecIn;
      assign vecOut = DEFAULT_VEC;
    end
  endgenerate

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqLive,
  input  logic        takeReady,
  input  logic        retExec,
  input  logic        enSet,
  input  logic        enClr,
  output logic        takeReq,
  output logic        enState,
  output logic [1:0]  ackCode,
  output ctrlStrobe_t strobe
);

  logic     enReg;
  ackCode_e ackReg;
  ackCode_e ackNext;
  logic     enNext;
  logic     takeNow;

  assign takeReq = enReg & reqLive;
  assign takeNow = takeReq & takeReady;

  always_comb begin
    strobe             = '0;
    strobe.takeNow     = takeNow;
    strobe.dropPending = takeNow;
  end

  // Enable bit: take first, then return or software set, then clear.
  always_comb begin
    if (takeNow)                 enNext = 1'b0;
    else if (retExec || enSet)   enNext = 1'b1;
    else if (enClr)              enNext = 1'b0;
    else                         enNext = enReg;
  end

  // Event code: entry beats return, return beats re-enable.
  always_comb begin
    if (takeNow)                 ackNext = ACK_ENTER;
    else if (retExec)            ackNext = ACK_RETURN;
    else if (enSet && !enReg)    ackNext = ACK_REENABLE;
    else                         ackNext = ACK_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enReg  <= 1'b0;
      ackReg <= ACK_IDLE;
    end else begin
      enReg  <= enNext;
      ackReg <= ackNext;
    end
  end

  assign enState = enReg;
  assign ackCode = ackReg;

endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import irq_entry_pkg::*;
#(
  parameter bit EDGE_MODE = 1'b1,
  parameter bit LOW_LATENCY = 1'b1,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] DEFAULT_VEC = 32'h0000_0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irqIn,
  input  logic [ADDR_W-1:0] vecIn,
  input  logic              takeReady,
  input  logic              retExec,
  input  logic              enSet,
  input  logic              enClr,
  output logic              takeReq,
  output logic [ADDR_W-1:0] takeVec,
  output logic              enState,
  output logic [1:0]        ackCode
);

  ctrlStrobe_t strobe;
  logic        reqLive;

  irq_entry_datapath #(
    .EDGE_MODE(EDGE_MODE),
    .LOW_LATENCY(LOW_LATENCY),
    .ADDR_W(ADDR_W),
    .DEFAULT_VEC(DEFAULT_VEC)
  ) dpI (
    .clk(clk),
    .rst(rst),
    .irqIn(irqIn),
    .vecIn(vecIn),
    .strobe(strobe),
    .reqLive(reqLive),
    .vecOut(takeVec)
  );

  irq_entry_ctrl ctI (
    .clk(clk),
    .rst(rst),
    .reqLive(reqLive),
    .takeReady(takeReady),
    .retExec(retExec),
    .enSet(enSet),
    .enClr(enClr),
    .takeReq(takeReq),
    .enState(enState),
    .ackCode(ackCode),
    .strobe(strobe)
  );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter bit EDGE_MODE = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       irqIn,
  input logic       takeReady,
  input logic       retExec,
  input logic       enSet,
  input logic       takeReq,
  input logic       enState,
  input logic [1:0] ackCode
);

  // R1
  masked_no_request_chk: assert property (@(posedge clk) disable iff (rst)
    !enState |-> !takeReq);

  // R7
  entry_code_chk: assert property (@(posedge clk) disable iff (rst)
    (takeReq && takeReady) |=> (ackCode == 2'b01) && !enState);

  // R8
  return_code_chk: assert property (@(posedge clk) disable iff (rst)
    (retExec && !(takeReq && takeReady)) |=> (ackCode == 2'b10) && enState);

  // R9
  reenable_code_chk: assert property (@(posedge clk) disable iff (rst)
    (enSet && !enState && !retExec) |=> (ackCode == 2'b11) && enState);

  // R10
  code_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (!(takeReq && takeReady) && !retExec && !(enSet && !enState)) |=> (ackCode == 2'b00));

  generate
    if (!EDGE_MODE) begin : g_level_chk
      // R2
      level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !irqIn |-> !takeReq);
    end
  endgenerate

endmodule

bind irq_entry_unit irq_entry_chk #(.EDGE_MODE(EDGE_MODE)) chkI (
  .clk(clk),
  .rst(rst),
  .irqIn(irqIn),
  .takeReady(takeReady),
  .retExec(retExec),
  .enSet(enSet),
  .takeReq(takeReq),
  .enState(enState),
  .ackCode(ackCode)
);

// File: tb/sim_irq_entry_unit.sv
module sim_irq_entry_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam logic [AW-1:0] FIXED_VEC = 32'h0000_0010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irqIn = 1'b0;
  logic [AW-1:0] vecIn = '0;
  logic takeReady = 1'b0;
  logic retExec = 1'b0;
  logic enSet = 1'b0;
  logic enClr = 1'b0;

  logic tq0, en0, tq1, en1;
  logic [AW-1:0] tv0, tv1;
  logic [1:0] ak0, ak1;

  int applied = 0;
  int failed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_unit #(.EDGE_MODE(1'b1), .LOW_LATENCY(1'b1), .ADDR_W(AW), .DEFAULT_VEC(FIXED_VEC)) u0 (
    .clk(clk), .rst(rst), .irqIn(irqIn), .vecIn(vecIn), .takeReady(takeReady),
    .retExec(retExec), .enSet(enSet), .enClr(enClr),
    .takeReq(tq0), .takeVec(tv0), .enState(en0), .ackCode(ak0));

  irq_entry_unit #(.EDGE_MODE(1'b0), .LOW_LATENCY(1'b0), .ADDR_W(AW), .DEFAULT_VEC(FIXED_VEC)) u1 (
    .clk(clk), .rst(rst), .irqIn(irqIn), .vecIn(vecIn), .takeReady(takeReady),
    .retExec(retExec), .enSet(enSet), .enClr(enClr),
    .takeReq(tq1), .takeVec(tv1), .enState(en1), .ackCode(ak1));

  // Behavioural model: index 0 edge-captured, index 1 level-read.
  logic mEn[2];
  logic mPend[2];
  logic mPrev[2];
  int   mAck[2];

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        mEn[i] = 1'b0; mPend[i] = 1'b0; mPrev[i] = 1'b0; mAck[i] = 0;
      end else begin
        bit wants, accepted, edgeNow;
        wants    = (i == 0) ? mPend[i] : irqIn;
        accepted = mEn[i] && wants && takeReady;
        edgeNow  = irqIn && !mPrev[i];
        if (accepted) mAck[i] = 1;
        else if (retExec) mAck[i] = 2;
        else if (enSet && !mEn[i]) mAck[i] = 3;
        else mAck[i] = 0;
        if (accepted) mEn[i] = 1'b0;
        else if (retExec || enSet) mEn[i] = 1'b1;
        else if (enClr) mEn[i] = 1'b0;
        if (i == 0) mPend[i] = edgeNow || (mPend[i] && !accepted);
        mPrev[i] = irqIn;
      end
    end
  end

  task automatic check(string tag, string what, longint act, longint exp);
    applied++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R1", "u0 takeReq", tq0, mEn[0] && mPend[0]);
    check("R1", "u1 takeReq", tq1, mEn[1] && irqIn);
    check("R6", "u0 takeVec", tv0, vecIn);
    check("R6", "u1 takeVec", tv1, FIXED_VEC);
    check("R7", "u0 enState", en0, mEn[0]);
    check("R7", "u1 enState", en1, mEn[1]);
    check("R10", "u0 ackCode", ak0, mAck[0]);
    check("R10", "u1 ackCode", ak1, mAck[1]);
  endtask

  // Drive at the falling edge, compare a quarter period later, then cross one rising edge.
  task automatic step(bit irq, bit set, bit clr, bit ret, bit rdy, logic [AW-1:0] vec);
    irqIn = irq; enSet = set; enClr = clr; retExec = ret; takeReady = rdy; vecIn = vec;
    #(CLK_PERIOD/4);
    compareAll();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failed++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "u0 enState", en0, 0);
    check("R1", "u0 ackCode", ak0, 0);
    check("R1", "u1 takeReq", tq1, 0);

    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    check("R5", "u0 takeReq masked", tq0, 0);
    step(0, 1, 0, 0, 0, 0);
    check("R9", "u0 ack reenable", ak0, 3);
    check("R9", "u1 ack reenable", ak1, 3);
    check("R5", "u0 latched request after enable", tq0, 1);
    check("R2", "u1 no latch", tq1, 0);
    step(0, 0, 0, 0, 0, 0);
    check("R10", "u0 ack back to idle", ak0, 0);
    step(0, 0, 0, 0, 1, 32'h0000_0ABC);
    check("R7", "u0 ack entry", ak0, 1);
    check("R7", "u0 enable cleared", en0, 0);
    step(0, 0, 0, 1, 0, 0);
    check("R8", "u0 ack return", ak0, 2);
    check("R8", "u0 enable set", en0, 1);
    step(0, 0, 0, 0, 0, 0);
    check("R7", "u0 pending cleared by take", tq0, 0);
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    check("R2", "u1 request gone with line", tq1, 0);
    check("R3", "u0 pulse latched", tq0, 1);
    step(1, 0, 0, 0, 1, 32'h0000_1234);
    check("R7", "u1 level take", ak1, 1);
    check("R7", "u0 edge take", ak0, 1);
    step(1, 0, 0, 1, 0, 0);
    check("R11", "u0 edge in take cycle kept", tq0, 1);
    check("R2", "u1 held line requests", tq1, 1);
    step(1, 0, 0, 0, 1, 32'h0000_2000);
    check("R7", "u0 second take", ak0, 1);
    step(1, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    check("R4", "u0 held line no new request", tq0, 0);
    step(1, 0, 0, 0, 1, 0);
    check("R4", "u0 no take while held", ak0, 0);
    check("R4", "u0 still enabled", en0, 1);
    step(0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    step(0, 1, 1, 1, 1, 32'h0000_3000);
    check("R12", "u0 take beats return", ak0, 1);
    check("R12", "u0 enable cleared", en0, 0);
    step(0, 1, 0, 0, 0, 0);
    check("R9", "u0 reenable code", ak0, 3);
    check("R9", "u1 already enabled", ak1, 0);
    step(0, 0, 1, 0, 0, 0);
    check("R9", "u0 clear no code", ak0, 0);
    check("R9", "u0 clear enable", en0, 0);

    for (int n = 0; n < 2000; n++) begin
      bit irq, s, c, r, y;
      irq = ($urandom_range(0, 3) == 0) ? ~irqIn : irqIn;
      s = ($urandom_range(0, 5) == 0);
      c = ($urandom_range(0, 7) == 0);
      r = ($urandom_range(0, 9) == 0);
      y = ($urandom_range(0, 2) != 0);
      step(irq, s, c, r, y, $urandom);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end
endmodule